// File: doc/BRIEF.md
# Stack Pointer Unit with Privilege Check

This block keeps the two stack pointers of a small 8-bit stack processor that addresses 64 KB of memory: one for the data stack and one for the return stack. Each pointer is made of a narrow counting field, which moves on push and pop strobes, and a high-address register that holds the rest of the address. The counting field wraps inside its own width and never carries into the high register. A push increments the field before the access and a pop decrements it after the access, so the pointer always holds the address of the top stored element.

Software can reload either pointer with a full 16-bit value, for example to switch threads. Such a reload is accepted only when the program counter of the instruction doing the write lies in the privileged region at the bottom of memory (addresses below 0x1000). A reload attempted from anywhere else is dropped, and a one-cycle trap request is raised with a flag naming the pointer that was targeted. When a stack access is enabled, the unit drives the selected pointer onto the memory address output.

Top module: `stack_ptr_unit`

## Requirements
- R1: While rstN is low and on the first cycle after it, dataPtr and retPtr read 0x0000 and trapReq reads 0.
- R2: A data push (pushData without popData) adds one to bits 7:0 of dataPtr on the next clock; 0xFF wraps to 0x00 and bits 15:8 never change through counting.
- R3: A return push or pop changes only bits 3:0 of retPtr, wrapping 0xF to 0x0 upward and 0x0 to 0xF downward; bits 15:4 never change through counting.
- R4: A pop without a push on the same stack subtracts one from that pointer's counting field on the next clock, with 0x00 wrapping to 0xFF for the data stack.
- R5: A push and a pop on the same stack in the same cycle leave that pointer unchanged.
- R6: A write strobe (wrData or wrRet) with pcValue below 0x1000 loads wrValue into the whole target pointer on the next clock, taking priority over any push or pop on that stack in the same cycle.
- R7: A write strobe with pcValue at or above 0x1000 has no effect on the target pointer.
- R8: The cycle after a refused write, trapReq is 1 for exactly that cycle (unless another refused write follows) and trapCause is 0 for the data pointer and 1 for the return pointer.
- R9: memAddr is 0x0000 when stkEn is 0; when stkEn is 1, stkSel=0 selects the data stack and stkSel=1 the return stack, and the address is the selected pointer with its counting field plus one while that stack is pushed without a pop or an accepted write, otherwise the selected pointer as it stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushData | input | 1 | Push strobe, data stack |
| popData | input | 1 | Pop strobe, data stack |
| pushRet | input | 1 | Push strobe, return stack |
| popRet | input | 1 | Pop strobe, return stack |
| wrData | input | 1 | Request to reload the data pointer |
| wrRet | input | 1 | Request to reload the return pointer |
| wrValue | input | 16 | Value for a pointer reload |
| pcValue | input | 16 | Program counter of the instruction issuing the current strobes |
| stkEn | input | 1 | Stack access enable for the address output |
| stkSel | input | 1 | Stack selected for the address output (0 data, 1 return) |
| memAddr | output | 16 | Memory address driven for a stack access |
| dataPtr | output | 16 | Current data stack pointer |
| retPtr | output | 16 | Current return stack pointer |
| trapReq | output | 1 | One-cycle trap request after a refused reload |
| trapCause | output | 1 | Pointer targeted by the refused reload (0 data, 1 return) |

## Verification
The assertions assume that wrData and wrRet are never high in the same cycle, since the trap carries a single cause flag; the bench drives at most one write strobe per cycle, in directed steps and in its random mix alike. They also take the inputs to be free of unknown values once reset is released, and the bench drives every input to a defined level from time zero and changes them only at the falling clock edge. Push and pop strobes are otherwise unconstrained, so simultaneous push and pop, and writes coinciding with counting, do occur in the stimulus.

// File: rtl/spu_pkg.sv
package spu_pkg;

  // Strobes from control to datapath: at most one of ld/inc/dec per stack.
  typedef struct packed {
    logic ldData;
    logic incData;
    logic decData;
    logic ldRet;
    logic incRet;
    logic decRet;
  } spuStrobes_t;

endpackage

// File: rtl/spu_ptr.sv
module spu_ptr #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ld,
  input  logic              inc,
  input  logic              dec,
  input  logic [ADDR_W-1:0] ldValue,
  output logic [ADDR_W-1:0] ptrQ,
  output logic [ADDR_W-1:0] ptrUp
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [HI_W-1:0]  hiQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ  <= '0;
      cntQ <= '0;
    end else if (ld) begin
      {hiQ, cntQ} <= ldValue;
    end else if (inc) begin
      cntQ <= cntQ + CNT_W'(1);
    end else if (dec) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign ptrQ  = {hiQ, cntQ};
  assign ptrUp = {hiQ, cntQ + CNT_W'(1)};

  // R2 / R3: counting never reaches the high register
  a_r3_hi_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ld |=> $stable(hiQ));

  // R5: with no strobe the counting field holds
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ld && !inc && !dec) |=> $stable(cntQ));

endmodule

// File: rtl/spu_ctrl.sv
module spu_ctrl
  import spu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PRIV_SPAN_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushData,
  input  logic              popData,
  input  logic              pushRet,
  input  logic              popRet,
  input  logic              wrData,
  input  logic              wrRet,
  input  logic [ADDR_W-1:0] pcValue,
  output spuStrobes_t       strobes,
  output logic              trapReq,
  output logic              trapCause
);
  localparam logic [ADDR_W-1:0] PRIV_LIMIT = ADDR_W'(1) << PRIV_SPAN_W;

  logic privOk;
  logic refused;

  assign privOk  = pcValue < PRIV_LIMIT;
  assign refused = (wrData || wrRet) && !privOk;

  always_comb begin
    strobes.ldData  = wrData && privOk;
    strobes.incData = !strobes.ldData && pushData && !popData;
    strobes.decData = !strobes.ldData && popData && !pushData;
    strobes.ldRet   = wrRet && privOk;
    strobes.incRet  = !strobes.ldRet && pushRet && !popRet;
    strobes.decRet  = !strobes.ldRet && popRet && !pushRet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapReq   <= 1'b0;
      trapCause <= 1'b0;
    end else begin
      trapReq   <= refused;
      trapCause <= refused ? wrRet : trapCause;
    end
  end

  // input assumption: one write strobe at a time
  a_in_single_write: assert property (@(posedge clk) disable iff (!rstN)
    !(wrData && wrRet));

  // R8: refused data write -> trap with cause 0
  a_r8_cause_data: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && pcValue >= PRIV_LIMIT) |=> (trapReq && !trapCause));

  // R8: refused return write -> trap with cause 1
  a_r8_cause_ret: assert property (@(posedge clk) disable iff (!rstN)
    (wrRet && pcValue >= PRIV_LIMIT) |=> (trapReq && trapCause));

  // R8: no trap without a refused write the cycle before
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !((wrData || wrRet) && pcValue >= PRIV_LIMIT) |=> !trapReq);

endmodule

// File: rtl/spu_dpath.sv
module spu_dpath
  import spu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DCNT_W  = 8,
  parameter int RCNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  spuStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrValue,
  input  logic              stkEn,
  input  logic              stkSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] dataPtr,
  output logic [ADDR_W-1:0] retPtr
);
  logic [ADDR_W-1:0] dataUp;
  logic [ADDR_W-1:0] retUp;

  spu_ptr #(.ADDR_W(ADDR_W), .CNT_W(DCNT_W)) dataPtr_i (
    .clk     (clk),
    .rstN    (rstN),
    .ld      (strobes.ldData),
    .inc     (strobes.incData),
    .dec     (strobes.decData),
    .ldValue (wrValue),
    .ptrQ    (dataPtr),
    .ptrUp   (dataUp)
  );

  spu_ptr #(.ADDR_W(ADDR_W), .CNT_W(RCNT_W)) retPtr_i (
    .clk     (clk),
    .rstN    (rstN),
    .ld      (strobes.ldRet),
    .inc     (strobes.incRet),
    .dec     (strobes.decRet),
    .ldValue (wrValue),
    .ptrQ    (retPtr),
    .ptrUp   (retUp)
  );

  // pre-increment: a push addresses the slot it is about to fill
  always_comb begin
    memAddr = '0;
    if (stkEn) begin
      if (stkSel) memAddr = strobes.incRet  ? retUp  : retPtr;
      else        memAddr = strobes.incData ? dataUp : dataPtr;
    end
  end

  // R9: address bus idle when no access is enabled
  a_r9_idle_addr: assert property (@(posedge clk) disable iff (!rstN)
    !stkEn |-> (memAddr == '0));

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import spu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DCNT_W      = 8,
  parameter int RCNT_W      = 4,
  parameter int PRIV_SPAN_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushData,
  input  logic              popData,
  input  logic              pushRet,
  input  logic              popRet,
  input  logic              wrData,
  input  logic              wrRet,
  input  logic [ADDR_W-1:0] wrValue,
  input  logic [ADDR_W-1:0] pcValue,
  input  logic              stkEn,
  input  logic              stkSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] dataPtr,
  output logic [ADDR_W-1:0] retPtr,
  output logic              trapReq,
  output logic              trapCause
);
  localparam logic [ADDR_W-1:0] PRIV_LIMIT = ADDR_W'(1) << PRIV_SPAN_W;

  spuStrobes_t strobes;

  spu_ctrl #(.ADDR_W(ADDR_W), .PRIV_SPAN_W(PRIV_SPAN_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pushData  (pushData),
    .popData   (popData),
    .pushRet   (pushRet),
    .popRet    (popRet),
    .wrData    (wrData),
    .wrRet     (wrRet),
    .pcValue   (pcValue),
    .strobes   (strobes),
    .trapReq   (trapReq),
    .trapCause (trapCause)
  );

  spu_dpath #(.ADDR_W(ADDR_W), .DCNT_W(DCNT_W), .RCNT_W(RCNT_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrValue (wrValue),
    .stkEn   (stkEn),
    .stkSel  (stkSel),
    .memAddr (memAddr),
    .dataPtr (dataPtr),
    .retPtr  (retPtr)
  );

  // R6: privileged write lands in full
  a_r6_data_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && pcValue < PRIV_LIMIT) |=> (dataPtr == $past(wrValue)));

  a_r6_ret_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrRet && pcValue < PRIV_LIMIT) |=> (retPtr == $past(wrValue)));

  // R7: refused write with no counting leaves the pointer alone
  a_r7_data_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && pcValue >= PRIV_LIMIT && pushData == popData) |=> $stable(dataPtr));

  a_r7_ret_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (wrRet && pcValue >= PRIV_LIMIT && pushRet == popRet) |=> $stable(retPtr));

  // R5: push with pop, no write, holds the data pointer
  a_r5_data_balance: assert property (@(posedge clk) disable iff (!rstN)
    (pushData && popData && !wrData) |=> $stable(dataPtr));

endmodule

// File: tb/stack_ptr_unit_tb_top.sv
`timescale 1ns/1ps
module stack_ptr_unit_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN;
  logic        pushData, popData, pushRet, popRet, wrData, wrRet;
  logic [15:0] wrValue, pcValue;
  logic        stkEn, stkSel;
  logic [15:0] memAddr, dataPtr, retPtr;
  logic        trapReq, trapCause;

  stack_ptr_unit dut_i (
    .clk(clk), .rstN(rstN),
    .pushData(pushData), .popData(popData), .pushRet(pushRet), .popRet(popRet),
    .wrData(wrData), .wrRet(wrRet), .wrValue(wrValue), .pcValue(pcValue),
    .stkEn(stkEn), .stkSel(stkSel), .memAddr(memAddr),
    .dataPtr(dataPtr), .retPtr(retPtr), .trapReq(trapReq), .trapCause(trapCause)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";
  bit    finished = 0;

  // reference model state
  int mDHi = 0, mDCnt = 0, mRHi = 0, mRCnt = 0;
  int mTrap = 0, mCause = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL all watchdog act=running exp=finished");
    finish_run();
  end

  function automatic int expAddr(bit pd, bit pp, bit rd, bit rp, bit wd, bit wr,
                                 int pc, bit en, bit sel);
    bool_priv: begin end
    if (!en) return 0;
    if (!sel) begin
      if (pd && !pp && !(wd && pc < 4096)) return mDHi * 256 + (mDCnt + 1) % 256;
      return mDHi * 256 + mDCnt;
    end
    if (rd && !rp && !(wr && pc < 4096)) return mRHi * 16 + (mRCnt + 1) % 16;
    return mRHi * 16 + mRCnt;
  endfunction

  task automatic cyc(bit pd, bit pp, bit rd, bit rp, bit wd, bit wr,
                     int wv, int pc, bit en, bit sel);
    bit priv;
    @(negedge clk);
    pushData = pd; popData = pp; pushRet = rd; popRet = rp;
    wrData = wd; wrRet = wr; wrValue = 16'(wv); pcValue = 16'(pc);
    stkEn = en; stkSel = sel;
    #1;
    chk("memAddr(R9)", memAddr, expAddr(pd, pp, rd, rp, wd, wr, pc, en, sel));
    @(posedge clk);
    priv = (pc < 4096);
    if (wd && priv) begin mDHi = (wv >> 8) & 255; mDCnt = wv & 255; end
    else if (pd && !pp) mDCnt = (mDCnt + 1) % 256;
    else if (pp && !pd) mDCnt = (mDCnt + 255) % 256;
    if (wr && priv) begin mRHi = (wv >> 4) & 4095; mRCnt = wv & 15; end
    else if (rd && !rp) mRCnt = (mRCnt + 1) % 16;
    else if (rp && !rd) mRCnt = (mRCnt + 15) % 16;
    if ((wd || wr) && !priv) begin mTrap = 1; mCause = wr; end
    else mTrap = 0;
    #1;
    chk("dataPtr", dataPtr, mDHi * 256 + mDCnt);
    chk("retPtr", retPtr, mRHi * 16 + mRCnt);
    chk("trapReq(R8)", trapReq, mTrap);
    if (mTrap) chk("trapCause(R8)", trapCause, mCause);
  endtask

  initial begin
    rstN = 0;
    pushData = 0; popData = 0; pushRet = 0; popRet = 0;
    wrData = 0; wrRet = 0; wrValue = 0; pcValue = 0; stkEn = 0; stkSel = 0;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    chk("dataPtr in reset", dataPtr, 0);
    chk("retPtr in reset", retPtr, 0);
    chk("trapReq in reset", trapReq, 0);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    chk("dataPtr after reset", dataPtr, 0);
    chk("retPtr after reset", retPtr, 0);
    chk("trapReq after reset", trapReq, 0);

    // R6: privileged loads, one pushing at the same time
    tag = "R6";
    cyc(1, 0, 0, 0, 1, 0, 'h12FE, 'h0100, 0, 0);
    cyc(0, 0, 1, 0, 0, 1, 'hABCE, 'h0FFF, 0, 0);

    // R2: data push wraps in low byte
    tag = "R2";
    repeat (3) cyc(1, 0, 0, 0, 0, 0, 0, 'h2000, 0, 0);
    chk("R2 high byte kept", dataPtr, 'h1201);

    // R3: return push wraps in low nibble
    tag = "R3";
    repeat (3) cyc(0, 0, 1, 0, 0, 0, 0, 'h2000, 0, 0);
    chk("R3 high bits kept", retPtr, 'hABC1);
    repeat (2) cyc(0, 0, 0, 1, 0, 0, 0, 'h2000, 0, 0);
    chk("R3 downward wrap", retPtr, 'hABCF);

    // R4: data pop wraps downward
    tag = "R4";
    repeat (3) cyc(0, 1, 0, 0, 0, 0, 0, 'h2000, 0, 0);
    chk("R4 pop wrap", dataPtr, 'h12FE);

    // R5: simultaneous push and pop
    tag = "R5";
    repeat (2) cyc(1, 1, 1, 1, 0, 0, 0, 'h2000, 1, 0);

    // R7 / R8: refused writes
    tag = "R7";
    cyc(0, 0, 0, 0, 1, 0, 'h5555, 'h1000, 0, 0);
    chk("R7 data unchanged", dataPtr, 'h12FE);
    tag = "R8";
    cyc(0, 0, 0, 0, 0, 1, 'h3333, 'hFFFF, 0, 0);
    chk("R7 ret unchanged", retPtr, 'hABCF);
    cyc(0, 0, 0, 0, 0, 0, 0, 'hFFFF, 0, 0);
    chk("R8 pulse ends", trapReq, 0);

    // R9: address selection and pre-increment
    tag = "R9";
    cyc(1, 0, 0, 0, 0, 0, 0, 'h2000, 1, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, 'h2000, 1, 1);
    cyc(0, 0, 0, 1, 0, 0, 0, 'h2000, 1, 1);
    cyc(0, 1, 0, 0, 0, 0, 0, 'h2000, 1, 0);
    cyc(1, 0, 1, 0, 0, 0, 0, 'h2000, 0, 1);

    // random mix
    tag = "mix";
    for (int i = 0; i < 600; i++) begin
      int w;
      int pc;
      w  = $urandom_range(0, 7);
      pc = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 'h0FFF)
                                       : $urandom_range('h1000, 'hFFFF);
      cyc($urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom_range(0, 1),
          w == 0, w == 1, $urandom_range(0, 'hFFFF), pc,
          $urandom_range(0, 1), $urandom_range(0, 1));
    end
    finish_run();
  end

endmodule